// File: doc/BRIEF.md
# Dual-View LCD Timing and Interrupt Generator

This block produces the horizontal and vertical timing of a 256x192 display and turns the timing events into interrupt requests for two processors. One shared timing engine counts dots within a line and lines within a frame. Each line is an active-draw phase followed by a horizontal-blank phase. Each frame is a run of visible lines, then a vertical-blank run, then one final blank line on which the vertical-blank flag is already clear. The engine moves forward only on a dot-enable strobe, so one dot may take any number of clock cycles.

Two independent view register sets, side A and side B, watch the shared timing. Each side has its own line-compare value and its own three interrupt enables. Each side keeps its own coincidence flag and raises its own one-cycle interrupt request pulses. A one-cycle frame-buffer swap pulse marks the start of vertical blank.

The horizontal state machine `lcdt_dot_fsm` has two states. PH_DRAW goes to PH_HBLANK on the strobe that ends the last active dot, which is the hblank-start transition. PH_HBLANK goes back to PH_DRAW on the strobe that ends the last blank dot, which is the line-advance transition. The vertical state machine `lcdt_line_ctr` has three states. VR_VISIBLE goes to VR_VBLANK when the line advances to the first non-visible line, which is the vblank-start transition. VR_VBLANK goes to VR_FINAL when the line advances to the last line number, which is the vblank-end transition. VR_FINAL goes to VR_VISIBLE when the line wraps to 0, which is the frame-wrap transition.

Top module: `lcd_timing_gen`

## Requirements
- R1: After reset, line is 0, hblank, vblank, fb_swap, both coincidence flags and all interrupt bits are 0. Both compare values and all enables are 0.
- R2: Counting from the start of a line, hblank rises on the ACTIVE_DOTS-th dot strobe. It falls on the (ACTIVE_DOTS+BLANK_DOTS)-th strobe, in the same cycle that line advances. This happens on every line, blank lines included.
- R3: line steps by one on each line advance, from 0 up to TOTAL_LINES-1, and then wraps to 0.
- R4: vblank rises in the cycle line becomes VIS_LINES. It falls in the cycle line becomes TOTAL_LINES-1. It stays 0 through the wrap to line 0.
- R5: fb_swap is a one-cycle pulse, high exactly in the cycle vblank rises.
- R6: On every line advance, each side's coincidence flag is rewritten to (new line == that side's compare value). Between advances the flag holds.
- R7: Interrupt bit 2 of a side pulses for one cycle at a line advance when the new line equals that side's compare value and that side's enable bit 2 is 1.
- R8: Interrupt bit 1 of a side pulses for one cycle in the cycle hblank rises, if that side's enable bit 1 is 1. This includes blank lines.
- R9: Interrupt bit 0 of a side pulses for one cycle in the cycle vblank rises, if that side's enable bit 0 is 1.
- R10: Sides A and B are independent. A write to one side's compare value or enables changes nothing on the other side's outputs.
- R11: While dot_en is 0, line, hblank and vblank hold and no interrupt or swap pulse is produced.
- R12: A compare write does not change the coincidence flag when it happens. The new value is first used at the next line advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dot_en | input | 1 | One-cycle strobe; advances timing by one dot |
| a_cmp_we | input | 1 | Side A compare write strobe |
| a_cmp_wdata | input | LINE_W | Side A compare value |
| a_en_we | input | 1 | Side A enable write strobe |
| a_en_wdata | input | 3 | Side A enables: bit0 vblank, bit1 hblank, bit2 coincidence |
| b_cmp_we | input | 1 | Side B compare write strobe |
| b_cmp_wdata | input | LINE_W | Side B compare value |
| b_en_we | input | 1 | Side B enable write strobe |
| b_en_wdata | input | 3 | Side B enables, same bit layout as side A |
| hblank | output | 1 | Horizontal-blank status |
| vblank | output | 1 | Vertical-blank status |
| line | output | LINE_W | Current line number |
| a_coin | output | 1 | Side A coincidence flag |
| b_coin | output | 1 | Side B coincidence flag |
| a_irq | output | 3 | Side A interrupt pulses: bit0 vblank, bit1 hblank, bit2 coincidence |
| b_irq | output | 3 | Side B interrupt pulses, same bit layout |
| fb_swap | output | 1 | Frame-buffer swap pulse |

## Verification
A wrong dot count or a wrong horizontal state shows up on hblank and line within one strobe of the faulty transition. Because every later line inherits that phase error, the fault persists for the rest of the run. A wrong vertical state puts vblank, fb_swap or interrupt bit 0 on the wrong line, and this becomes visible within one line of the mistake. A fault in a side's compare or enable register shows at the next line advance, as a coincidence flag or interrupt bit 2 that disagrees with the line number. A mixed-up side shows as side B tracking side A's settings.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

    // Horizontal phase of the dot sequencer
    typedef enum logic [0:0] {
        PH_DRAW   = 1'b0,
        PH_HBLANK = 1'b1
    } phase_e;

    // Vertical region of the line counter
    typedef enum logic [1:0] {
        VR_VISIBLE = 2'd0,
        VR_VBLANK  = 2'd1,
        VR_FINAL   = 2'd2
    } vregion_e;

    // Interrupt request bit positions
    localparam int IRQ_VBL  = 0;
    localparam int IRQ_HBL  = 1;
    localparam int IRQ_COIN = 2;
    localparam int IRQ_W    = 3;

endpackage

// File: rtl/lcdt_dot_fsm.sv
module lcdt_dot_fsm
    import lcdt_pkg::*;
#(
    parameter int ACTIVE_DOTS = 256,
    parameter int BLANK_DOTS  = 99
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   dot_en,
    output phase_e phase,
    output logic   hb_start,
    output logic   line_adv
);
    localparam int DOT_MAX = (ACTIVE_DOTS > BLANK_DOTS) ? ACTIVE_DOTS : BLANK_DOTS;
    localparam int DOT_W   = $clog2(DOT_MAX + 1);
    localparam logic [DOT_W-1:0] ACT_LAST = DOT_W'(ACTIVE_DOTS - 1);
    localparam logic [DOT_W-1:0] BLK_LAST = DOT_W'(BLANK_DOTS - 1);

    phase_e           state_q, state_d;
    logic [DOT_W-1:0] dot_q, dot_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_DRAW;
            dot_q   <= '0;
        end else begin
            state_q <= state_d;
            dot_q   <= dot_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        dot_d   = dot_q;
        if (dot_en) begin
            unique case (state_q)
                PH_DRAW: begin
                    if (dot_q == ACT_LAST) begin
                        state_d = PH_HBLANK;
                        dot_d   = '0;
                    end else begin
                        dot_d = dot_q + DOT_W'(1);
                    end
                end
                PH_HBLANK: begin
                    if (dot_q == BLK_LAST) begin
                        state_d = PH_DRAW;
                        dot_d   = '0;
                    end else begin
                        dot_d = dot_q + DOT_W'(1);
                    end
                end
                default: begin
                    state_d = PH_DRAW;
                    dot_d   = '0;
                end
            endcase
        end
    end

    // Outputs: transition events
    always_comb begin
        hb_start = 1'b0;
        line_adv = 1'b0;
        unique case (state_q)
            PH_DRAW:   hb_start = dot_en && (dot_q == ACT_LAST);
            PH_HBLANK: line_adv = dot_en && (dot_q == BLK_LAST);
            default: ;
        endcase
    end

    assign phase = state_q;

    a_r11_hold_dot: assert property (@(posedge clk) disable iff (!rst_n)
        !dot_en |=> $stable(state_q) && $stable(dot_q));

    a_r2_draw_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_DRAW) |-> (dot_q < DOT_W'(ACTIVE_DOTS)));

    a_r2_blank_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_HBLANK) |-> (dot_q < DOT_W'(BLANK_DOTS)));

endmodule

// File: rtl/lcdt_line_ctr.sv
module lcdt_line_ctr
    import lcdt_pkg::*;
#(
    parameter int VIS_LINES   = 192,
    parameter int TOTAL_LINES = 263,
    parameter int LINE_W      = $clog2(TOTAL_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_adv,
    output logic [LINE_W-1:0] line_q,
    output logic [LINE_W-1:0] next_line,
    output logic              vblank,
    output logic              vbl_start,
    output logic              fb_swap_q
);
    localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(TOTAL_LINES - 1);
    localparam logic [LINE_W-1:0] VBL_LINE  = LINE_W'(VIS_LINES);

    vregion_e reg_q, reg_d;

    assign next_line = (line_q == LAST_LINE) ? '0 : line_q + LINE_W'(1);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q     <= VR_VISIBLE;
            line_q    <= '0;
            fb_swap_q <= 1'b0;
        end else begin
            reg_q     <= reg_d;
            fb_swap_q <= vbl_start;
            if (line_adv) begin
                line_q <= next_line;
            end
        end
    end

    // Next state and transition events
    always_comb begin
        reg_d     = reg_q;
        vbl_start = 1'b0;
        if (line_adv) begin
            unique case (reg_q)
                VR_VISIBLE: begin
                    if (next_line == VBL_LINE) begin
                        reg_d     = VR_VBLANK;
                        vbl_start = 1'b1;
                    end
                end
                VR_VBLANK: begin
                    if (next_line == LAST_LINE) begin
                        reg_d = VR_FINAL;
                    end
                end
                VR_FINAL: begin
                    reg_d = VR_VISIBLE;
                end
                default: reg_d = VR_VISIBLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        unique case (reg_q)
            VR_VBLANK: vblank = 1'b1;
            default:   vblank = 1'b0;
        endcase
    end

    a_r3_line_range: assert property (@(posedge clk) disable iff (!rst_n)
        line_q <= LAST_LINE);

    a_r4_vbl_rise_line: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vblank) |-> (line_q == VBL_LINE));

    a_r4_vbl_fall_line: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vblank) |-> (line_q == LAST_LINE));

    a_r3_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !line_adv |=> $stable(line_q));

endmodule

// File: rtl/lcdt_view_regs.sv
module lcdt_view_regs
    import lcdt_pkg::*;
#(
    parameter int LINE_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_we,
    input  logic [LINE_W-1:0] cmp_wdata,
    input  logic              en_we,
    input  logic [IRQ_W-1:0]  en_wdata,
    input  logic              line_adv,
    input  logic [LINE_W-1:0] next_line,
    input  logic              hb_start,
    input  logic              vbl_start,
    output logic              coin_q,
    output logic [IRQ_W-1:0]  irq_q
);
    logic [LINE_W-1:0] cmp_q;
    logic [IRQ_W-1:0]  en_q;
    logic              match;
    logic [IRQ_W-1:0]  irq_d;

    assign match = (next_line == cmp_q);

    always_comb begin
        irq_d           = '0;
        irq_d[IRQ_VBL]  = vbl_start && en_q[IRQ_VBL];
        irq_d[IRQ_HBL]  = hb_start && en_q[IRQ_HBL];
        irq_d[IRQ_COIN] = line_adv && match && en_q[IRQ_COIN];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q  <= '0;
            en_q   <= '0;
            coin_q <= 1'b0;
            irq_q  <= '0;
        end else begin
            irq_q <= irq_d;
            if (cmp_we) begin
                cmp_q <= cmp_wdata;
            end
            if (en_we) begin
                en_q <= en_wdata;
            end
            if (line_adv) begin
                coin_q <= match;
            end
        end
    end

    a_r6_coin_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !line_adv |=> $stable(coin_q));

    a_r7_irq_needs_coin: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q[IRQ_COIN] |-> coin_q);

    a_r7_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q[IRQ_COIN] |=> !irq_q[IRQ_COIN]);

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
    import lcdt_pkg::*;
#(
    parameter int ACTIVE_DOTS = 256,
    parameter int BLANK_DOTS  = 99,
    parameter int VIS_LINES   = 192,
    parameter int TOTAL_LINES = 263,
    localparam int LINE_W     = $clog2(TOTAL_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dot_en,
    input  logic              a_cmp_we,
    input  logic [LINE_W-1:0] a_cmp_wdata,
    input  logic              a_en_we,
    input  logic [2:0]        a_en_wdata,
    input  logic              b_cmp_we,
    input  logic [LINE_W-1:0] b_cmp_wdata,
    input  logic              b_en_we,
    input  logic [2:0]        b_en_wdata,
    output logic              hblank,
    output logic              vblank,
    output logic [LINE_W-1:0] line,
    output logic              a_coin,
    output logic              b_coin,
    output logic [2:0]        a_irq,
    output logic [2:0]        b_irq,
    output logic              fb_swap
);
    localparam int NUM_VIEWS = 2;

    phase_e            phase;
    logic              hb_start;
    logic              line_adv;
    logic              vbl_start;
    logic [LINE_W-1:0] next_line;

    logic              cmp_we_v  [NUM_VIEWS];
    logic [LINE_W-1:0] cmp_dat_v [NUM_VIEWS];
    logic              en_we_v   [NUM_VIEWS];
    logic [IRQ_W-1:0]  en_dat_v  [NUM_VIEWS];
    logic              coin_v    [NUM_VIEWS];
    logic [IRQ_W-1:0]  irq_v     [NUM_VIEWS];

    lcdt_dot_fsm #(
        .ACTIVE_DOTS (ACTIVE_DOTS),
        .BLANK_DOTS  (BLANK_DOTS)
    ) u_dot (
        .clk      (clk),
        .rst_n    (rst_n),
        .dot_en   (dot_en),
        .phase    (phase),
        .hb_start (hb_start),
        .line_adv (line_adv)
    );

    lcdt_line_ctr #(
        .VIS_LINES   (VIS_LINES),
        .TOTAL_LINES (TOTAL_LINES),
        .LINE_W      (LINE_W)
    ) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_adv  (line_adv),
        .line_q    (line),
        .next_line (next_line),
        .vblank    (vblank),
        .vbl_start (vbl_start),
        .fb_swap_q (fb_swap)
    );

    assign cmp_we_v[0]  = a_cmp_we;
    assign cmp_dat_v[0] = a_cmp_wdata;
    assign en_we_v[0]   = a_en_we;
    assign en_dat_v[0]  = a_en_wdata;
    assign cmp_we_v[1]  = b_cmp_we;
    assign cmp_dat_v[1] = b_cmp_wdata;
    assign en_we_v[1]   = b_en_we;
    assign en_dat_v[1]  = b_en_wdata;

    for (genvar s = 0; s < NUM_VIEWS; s++) begin : g_view
        lcdt_view_regs #(
            .LINE_W (LINE_W)
        ) u_view (
            .clk       (clk),
            .rst_n     (rst_n),
            .cmp_we    (cmp_we_v[s]),
            .cmp_wdata (cmp_dat_v[s]),
            .en_we     (en_we_v[s]),
            .en_wdata  (en_dat_v[s]),
            .line_adv  (line_adv),
            .next_line (next_line),
            .hb_start  (hb_start),
            .vbl_start (vbl_start),
            .coin_q    (coin_v[s]),
            .irq_q     (irq_v[s])
        );
    end

    assign hblank = (phase == PH_HBLANK);
    assign a_coin = coin_v[0];
    assign b_coin = coin_v[1];
    assign a_irq  = irq_v[0];
    assign b_irq  = irq_v[1];

    a_r5_swap_at_vbl: assert property (@(posedge clk) disable iff (!rst_n)
        fb_swap |-> $rose(vblank));

    a_r8_hbl_irq_a: assert property (@(posedge clk) disable iff (!rst_n)
        a_irq[IRQ_HBL] |-> $rose(hblank));

    a_r8_hbl_irq_b: assert property (@(posedge clk) disable iff (!rst_n)
        b_irq[IRQ_HBL] |-> $rose(hblank));

    a_r9_vbl_irq_a: assert property (@(posedge clk) disable iff (!rst_n)
        a_irq[IRQ_VBL] |-> $rose(vblank));

    a_r9_vbl_irq_b: assert property (@(posedge clk) disable iff (!rst_n)
        b_irq[IRQ_VBL] |-> $rose(vblank));

    a_r2_hbl_fall_adv: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hblank) |-> (line != $past(line)));

    a_r11_no_pulse_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !dot_en |=> (a_irq == '0) && (b_irq == '0) && !fb_swap);

endmodule

// File: tb/test_lcd_timing_gen.sv
module test_lcd_timing_gen;
    localparam int ACT = 6;
    localparam int BLK = 3;
    localparam int VIS = 5;
    localparam int TOT = 8;
    localparam int LL  = ACT + BLK;
    localparam int LW  = $clog2(TOT);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dot_en = 1'b0;
    logic          a_cmp_we = 1'b0, b_cmp_we = 1'b0;
    logic [LW-1:0] a_cmp_wdata = '0, b_cmp_wdata = '0;
    logic          a_en_we = 1'b0, b_en_we = 1'b0;
    logic [2:0]    a_en_wdata = '0, b_en_wdata = '0;
    logic          hblank, vblank, a_coin, b_coin, fb_swap;
    logic [LW-1:0] line;
    logic [2:0]    a_irq, b_irq;

    int checks = 0;
    int errors = 0;

    // Reference model state
    int          n = 0;
    int          m_cmp_a = 0, m_cmp_b = 0;
    logic [2:0]  m_en_a = '0, m_en_b = '0;
    logic        m_coin_a = 1'b0, m_coin_b = 1'b0;
    logic [2:0]  m_irq_a = '0, m_irq_b = '0;
    logic        m_swap = 1'b0;

    always #2 clk = ~clk;

    lcd_timing_gen #(
        .ACTIVE_DOTS (ACT),
        .BLANK_DOTS  (BLK),
        .VIS_LINES   (VIS),
        .TOTAL_LINES (TOT)
    ) i_lcd_timing_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .dot_en      (dot_en),
        .a_cmp_we    (a_cmp_we),
        .a_cmp_wdata (a_cmp_wdata),
        .a_en_we     (a_en_we),
        .a_en_wdata  (a_en_wdata),
        .b_cmp_we    (b_cmp_we),
        .b_cmp_wdata (b_cmp_wdata),
        .b_en_we     (b_en_we),
        .b_en_wdata  (b_en_wdata),
        .hblank      (hblank),
        .vblank      (vblank),
        .line        (line),
        .a_coin      (a_coin),
        .b_coin      (b_coin),
        .a_irq       (a_irq),
        .b_irq       (b_irq),
        .fb_swap     (fb_swap)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (strobes %0d)", req, act, exp, n);
        end
    endtask

    function automatic int cur_line();
        return (n / LL) % TOT;
    endfunction

    task automatic check_all();
        int ln;
        int pos;
        ln  = cur_line();
        pos = n % LL;
        chk("R3 line", int'(line), ln);
        chk("R2 hblank", int'(hblank), int'(pos >= ACT));
        chk("R4 vblank", int'(vblank), int'(ln >= VIS && ln < TOT - 1));
        chk("R5 fb_swap", int'(fb_swap), int'(m_swap));
        chk("R6 coin side A", int'(a_coin), int'(m_coin_a));
        chk("R10 coin side B", int'(b_coin), int'(m_coin_b));
        chk("R9 vblank irq A", int'(a_irq[0]), int'(m_irq_a[0]));
        chk("R8 hblank irq A", int'(a_irq[1]), int'(m_irq_a[1]));
        chk("R7 coin irq A", int'(a_irq[2]), int'(m_irq_a[2]));
        chk("R10 irq side B", int'(b_irq), int'(m_irq_b));
    endtask

    // One clock; drive at negedge, update model at the edge, sample at next negedge
    task automatic step(input bit en);
        bit hb, adv, vbs;
        int ln;
        dot_en = en;
        @(posedge clk);
        m_irq_a = '0;
        m_irq_b = '0;
        m_swap  = 1'b0;
        if (en) begin
            n++;
            ln  = cur_line();
            hb  = (n % LL) == ACT;
            adv = (n % LL) == 0;
            vbs = adv && (ln == VIS);
            m_swap = vbs;
            m_irq_a[0] = vbs && m_en_a[0];
            m_irq_b[0] = vbs && m_en_b[0];
            m_irq_a[1] = hb && m_en_a[1];
            m_irq_b[1] = hb && m_en_b[1];
            if (adv) begin
                m_coin_a = (ln == m_cmp_a);
                m_coin_b = (ln == m_cmp_b);
                m_irq_a[2] = m_coin_a && m_en_a[2];
                m_irq_b[2] = m_coin_b && m_en_b[2];
            end
        end
        @(negedge clk);
        dot_en = 1'b0;
        check_all();
    endtask

    task automatic wr_cmp(input bit side_b, input int val);
        if (side_b) begin
            b_cmp_we = 1'b1; b_cmp_wdata = LW'(val);
        end else begin
            a_cmp_we = 1'b1; a_cmp_wdata = LW'(val);
        end
        step(1'b0);
        a_cmp_we = 1'b0;
        b_cmp_we = 1'b0;
        if (side_b) m_cmp_b = val; else m_cmp_a = val;
    endtask

    task automatic wr_en(input bit side_b, input logic [2:0] val);
        if (side_b) begin
            b_en_we = 1'b1; b_en_wdata = val;
        end else begin
            a_en_we = 1'b1; a_en_wdata = val;
        end
        step(1'b0);
        a_en_we = 1'b0;
        b_en_we = 1'b0;
        if (side_b) m_en_b = val; else m_en_a = val;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic prev_line;
        logic prev_coin;
        repeat (3) @(negedge clk);
        // R1: reset state, including coincidence clear although compare resets to 0
        chk("R1 line", int'(line), 0);
        chk("R1 hblank", int'(hblank), 0);
        chk("R1 vblank", int'(vblank), 0);
        chk("R1 coin", int'(a_coin) + int'(b_coin), 0);
        chk("R1 irq", int'(a_irq) + int'(b_irq) + int'(fb_swap), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_all();

        for (int k = 0; k < 16; k++) begin
            wr_cmp(1'b0, k % TOT);
            wr_cmp(1'b1, (k * 3 + 1) % TOT);
            wr_en(1'b0, 3'(k % 8));
            wr_en(1'b1, 3'(7 - (k % 8)));
            for (int i = 0; i < TOT * LL; i++) begin
                if (k >= 8 && (i % 3) == 1) begin
                    // R11: an idle cycle holds everything
                    prev_line = line[0];
                    step(1'b0);
                    chk("R11 line held", int'(line[0]), int'(prev_line));
                end
                if ((k % 2) == 1 && i == LL + 2) begin
                    // R12: mid-line compare write leaves the flag alone until the next advance
                    prev_coin = a_coin;
                    wr_cmp(1'b0, (k + 2) % TOT);
                    chk("R12 coin unchanged at write", int'(a_coin), int'(prev_coin));
                end
                step(1'b1);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule